// File: doc/BRIEF.md
# Serial GF(2) Polynomial Multiply/Divide Unit

This block does bit-serial arithmetic on binary polynomials, with a fixed degree-4 polynomial Q(x) = x^4 + x + 1 as the operand. A polynomial enters on `din` one coefficient per accepted clock, highest power first. In divide mode the unit emits the quotient on `qout` one bit per accepted clock and keeps the remainder in its shift register. In multiply mode the same serial input produces the product stream on `qout`.

The feedback is a set of XOR taps placed at the nonzero low-order coefficients of Q. The `VARIANT` parameter picks one of two ways to build it. The internal form puts the XORs in series between the flip-flops. The external form combines flip-flop outputs through a parity tree and converts its state to present the same remainder. Both variants give the same results at the ports.

The caller clears the register before each new operation and holds `valid` high for each bit that should be shifted in. For a full product, the caller appends four zero bits after the multiplicand.

Top module: `lfsr_gf2_muldiv`

## Requirements
- R1: A synchronous active-high `rst` empties the register, so `rem` reads 0 on the first clock after reset.
- R2: `clear` empties the register on the next clock (`rem` = 0) and takes priority over `valid`.
- R3: While `valid` and `clear` are both low, the register does not change. `rem` stays the same whatever `din` and `mode` do.
- R4: Divide mode is selected with `mode` = 0. Feeding 11110101 (x^7+x^6+x^5+x^4+x^2+1, highest power first) into a cleared register gives `qout` = 0,0,0,0,1,1,1,0. After the last bit, `rem` = 4'b0111, where `rem[i]` is the coefficient of x^i.
- R5: In divide mode, an N-bit dividend (N >= 4) gives four leading zeros on `qout`, then the N-4 quotient coefficients, highest first. After the last bit, `rem` equals the dividend mod Q.
- R6: Multiply mode is selected with `mode` = 1. For an N-bit input followed by four zero bits, the N+4 `qout` bits are the coefficients of D(x)·Q(x), highest first.
- R7: After a multiplication that ends with four zero bits, `rem` reads 0.
- R8: Both settings of `VARIANT` (internal and external XOR placement) give the same `qout` sequences and the same final `rem` for the same stimulus.
- R9: While the register is empty, `qout` is 0 in divide mode and equals `din` in multiply mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Empty the register before a new operation |
| mode | input | 1 | 0 = divide, 1 = multiply |
| din | input | 1 | Serial polynomial coefficient, highest power first |
| valid | input | 1 | Shift `din` in on this clock |
| qout | output | 1 | Quotient bit (divide) or product bit (multiply) for the current `din` |
| rem | output | DEG (4) | Remainder coefficients, bit i = x^i |

## Verification
Several dividends are divided, each chosen to separate a different fault:
- The worked example 11110101 checks quotient and remainder together.
- Q itself must give a zero remainder and a single quotient bit.
- A lone x^8 and an all-ones word exercise long runs of feedback.
- A 16-bit mixed pattern checks the general case.

Products are formed from a single 1, which yields Q itself, and from two irregular words, with trailing zeros checked for an empty register. Idle gaps with toggling inputs in the middle of an operation, and a clear that coincides with `valid`, show that shifting is gated correctly. Both XOR placements are driven side by side so any difference between them shows up.

// File: rtl/lfsr_gf2_pkg.sv
package lfsr_gf2_pkg;

    // Structural choice for the XOR feedback
    typedef enum logic {
        VAR_INTERNAL = 1'b0,   // XORs in series between flops
        VAR_EXTERNAL = 1'b1    // XORs as a parity tree on flop outputs
    } variant_e;

    // Operation encoding as seen on the mode pin
    typedef enum logic {
        OP_DIV = 1'b0,
        OP_MUL = 1'b1
    } op_e;

    // Default polynomial: x^4 + x + 1 (leading term implied)
    localparam int             DEF_DEG  = 4;
    localparam logic [DEF_DEG-1:0] DEF_TAPS = 4'b0011;

    // Per-step control derived from the operation
    typedef struct packed {
        logic fb;     // feedback bit driving the taps
        logic shin;   // bit shifted into the low end
        logic outb;   // serial output bit
    } step_t;

endpackage

// File: rtl/lfsr_gf2_int_core.sv
module lfsr_gf2_int_core
    import lfsr_gf2_pkg::*;
#(
    parameter int             DEG  = DEF_DEG,
    parameter logic [DEG-1:0] TAPS = DEF_TAPS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           step,
    input  op_e            op,
    input  logic           din,
    output logic           qout,
    output logic [DEG-1:0] rem
);

    logic [DEG-1:0] r_q;
    logic [DEG-1:0] r_d;
    step_t          ctl;

    // Divide: the top bit leaves as the quotient and folds back through the taps.
    // Multiply: the input itself drives the taps, and the top bit adds the delayed terms.
    always_comb begin
        if (op == OP_MUL) begin
            ctl.fb   = din;
            ctl.shin = 1'b0;
            ctl.outb = din ^ r_q[DEG-1];
        end else begin
            ctl.fb   = r_q[DEG-1];
            ctl.shin = din;
            ctl.outb = r_q[DEG-1];
        end
        r_d = {r_q[DEG-2:0], ctl.shin} ^ (TAPS & {DEG{ctl.fb}});
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            r_q <= '0;
        end else if (step) begin
            r_q <= r_d;
        end
    end

    assign qout = ctl.outb;
    assign rem  = r_q;

endmodule

// File: rtl/lfsr_gf2_ext_core.sv
module lfsr_gf2_ext_core
    import lfsr_gf2_pkg::*;
#(
    parameter int             DEG  = DEF_DEG,
    parameter logic [DEG-1:0] TAPS = DEF_TAPS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           step,
    input  op_e            op,
    input  logic           din,
    output logic           qout,
    output logic [DEG-1:0] rem
);

    // s_q[k-1] holds the value shifted in k accepted steps ago
    logic [DEG-1:0] s_q;
    logic           par;
    logic [DEG-1:0] hi;
    step_t          ctl;

    // Parity tree: coefficient x^j of Q looks back DEG-j steps
    always_comb begin
        par = 1'b0;
        for (int j = 0; j < DEG; j++) begin
            par = par ^ (TAPS[j] & s_q[DEG-1-j]);
        end
    end

    always_comb begin
        ctl.fb = par;
        if (op == OP_MUL) begin
            ctl.shin = din;
            ctl.outb = din ^ par;
        end else begin
            ctl.shin = din ^ par;
            ctl.outb = s_q[DEG-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            s_q <= '0;
        end else if (step) begin
            s_q <= {s_q[DEG-2:0], ctl.shin};
        end
    end

    // The held look-ahead quotient T maps to remainder T + hi(T * Qlow) / x^DEG
    always_comb begin
        hi = '0;
        for (int j = 1; j < DEG; j++) begin
            if (TAPS[j]) begin
                hi = hi ^ (s_q >> (DEG - j));
            end
        end
        rem = s_q ^ hi;
    end

    assign qout = ctl.outb;

endmodule

// File: rtl/lfsr_gf2_muldiv.sv
module lfsr_gf2_muldiv
    import lfsr_gf2_pkg::*;
#(
    parameter int             DEG     = DEF_DEG,
    parameter logic [DEG-1:0] TAPS    = DEF_TAPS,
    parameter variant_e       VARIANT = VAR_INTERNAL
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           mode,
    input  logic           din,
    input  logic           valid,
    output logic           qout,
    output logic [DEG-1:0] rem
);

    op_e  op;
    logic step;

    assign op   = op_e'(mode);
    assign step = valid & ~clear;

    generate
        if (VARIANT == VAR_EXTERNAL) begin : g_ext
            lfsr_gf2_ext_core #(.DEG(DEG), .TAPS(TAPS)) u_core (
                .clk  (clk),
                .rst  (rst),
                .clear(clear),
                .step (step),
                .op   (op),
                .din  (din),
                .qout (qout),
                .rem  (rem)
            );
        end else begin : g_int
            lfsr_gf2_int_core #(.DEG(DEG), .TAPS(TAPS)) u_core (
                .clk  (clk),
                .rst  (rst),
                .clear(clear),
                .step (step),
                .op   (op),
                .din  (din),
                .qout (qout),
                .rem  (rem)
            );
        end
    endgenerate

endmodule

// File: rtl/lfsr_gf2_muldiv_chk.sv
module lfsr_gf2_muldiv_chk #(
    parameter int DEG = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           clear,
    input logic           mode,
    input logic           din,
    input logic           valid,
    input logic           qout,
    input logic [DEG-1:0] rem
);

    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> rem == '0);

    // R2
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> rem == '0);

    // R3
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!valid && !clear) |=> $stable(rem));

    // R9: empty register in divide mode never emits a quotient bit
    a_r9_div_empty: assert property (@(posedge clk) disable iff (rst)
        (rem == '0 && !mode) |-> !qout);

    // R9: empty register in multiply mode passes the input through
    a_r9_mul_empty: assert property (@(posedge clk) disable iff (rst)
        (rem == '0 && mode) |-> qout == din);

    // R7: zero input into an empty multiplier keeps it empty
    a_r7_mul_zero_stays: assert property (@(posedge clk) disable iff (rst)
        (valid && !clear && mode && !din && rem == '0) |=> rem == '0);

endmodule

bind lfsr_gf2_muldiv lfsr_gf2_muldiv_chk #(.DEG(DEG)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .clear(clear),
    .mode (mode),
    .din  (din),
    .valid(valid),
    .qout (qout),
    .rem  (rem)
);

// File: tb/tb_lfsr_gf2_muldiv.sv
module tb_lfsr_gf2_muldiv;
    import lfsr_gf2_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear = 1'b0;
    logic       mode = 1'b0;
    logic       din = 1'b0;
    logic       valid = 1'b0;
    logic       qout_i, qout_x;
    logic [3:0] rem_i, rem_x;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lfsr_gf2_muldiv #(.VARIANT(VAR_INTERNAL)) dut (
        .clk(clk), .rst(rst), .clear(clear), .mode(mode),
        .din(din), .valid(valid), .qout(qout_i), .rem(rem_i)
    );

    lfsr_gf2_muldiv #(.VARIANT(VAR_EXTERNAL)) dut_x (
        .clk(clk), .rst(rst), .clear(clear), .mode(mode),
        .din(din), .valid(valid), .qout(qout_x), .rem(rem_x)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R8: both variants are checked against the same expectation
    task automatic chk_both_q(input string req, input logic exp);
        chk(req, "qout int", {31'b0, qout_i}, {31'b0, exp});
        chk(req, "qout ext", {31'b0, qout_x}, {31'b0, exp});
    endtask

    task automatic chk_both_rem(input string req, input logic [3:0] exp);
        chk(req, "rem int", {28'b0, rem_i}, {28'b0, exp});
        chk(req, "rem ext", {28'b0, rem_x}, {28'b0, exp});
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1; valid = 1'b0;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic push(input logic m, input logic b, input string req, input logic expq);
        @(negedge clk);
        mode = m; din = b; valid = 1'b1; clear = 1'b0;
        #1;
        chk_both_q(req, expq);
    endtask

    task automatic idle_end();
        @(negedge clk); valid = 1'b0; din = 1'b0;
        #1;
    endtask

    // Long division of an n-bit dividend by x^4+x+1
    task automatic ref_div(input logic [31:0] d, input int n,
                           output logic [31:0] q, output logic [3:0] r);
        logic [31:0] v;
        v = d; q = '0;
        for (int i = n - 1; i >= 4; i--) begin
            if (v[i]) begin
                v = v ^ (32'h13 << (i - 4));
                q[i-4] = 1'b1;
            end
        end
        r = v[3:0];
    endtask

    task automatic run_div(input string req, input logic [31:0] d, input int n);
        logic [31:0] q;
        logic [3:0]  r;
        ref_div(d, n, q, r);
        do_clear();
        for (int t = 0; t < n; t++) begin
            push(1'b0, d[n-1-t], req, (t < 4) ? 1'b0 : q[n-1-t]);
        end
        idle_end();
        chk_both_rem(req, r);
    endtask

    task automatic run_mul(input logic [31:0] d, input int n);
        logic [35:0] p;
        logic [35:0] dd;
        dd = {4'b0, d};
        p  = (dd << 4) ^ (dd << 1) ^ dd;
        do_clear();
        for (int t = 0; t < n + 4; t++) begin
            push(1'b1, (t < n) ? d[n-1-t] : 1'b0, "R6", p[n+3-t]);
        end
        idle_end();
        chk_both_rem("R7", 4'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk_both_rem("R1", 4'h0);
        rst = 1'b0;
    endtask

    task automatic t_example();
        run_div("R4", 32'hF5, 8);
    endtask

    task automatic t_divide_patterns();
        run_div("R5", 32'h13, 5);      // Q itself
        run_div("R5", 32'h100, 9);     // x^8
        run_div("R5", 32'hFFF, 12);    // all ones
        run_div("R5", 32'hB3C5, 16);   // mixed
    endtask

    task automatic t_multiply_patterns();
        run_mul(32'h1, 1);
        run_mul(32'hB5, 8);
        run_mul(32'h1ACF, 13);
    endtask

    task automatic t_hold();
        logic [31:0] q;
        logic [3:0]  r, snap_i, snap_x;
        ref_div(32'hD6, 8, q, r);
        do_clear();
        for (int t = 0; t < 5; t++) push(1'b0, 1'(32'hD6 >> (7 - t)), "R3", (t < 4) ? 1'b0 : q[7-t]);
        idle_end();
        snap_i = rem_i; snap_x = rem_x;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); din = ~din; mode = ~mode; valid = 1'b0;
            #1;
            chk("R3", "rem int idle", {28'b0, rem_i}, {28'b0, snap_i});
            chk("R3", "rem ext idle", {28'b0, rem_x}, {28'b0, snap_x});
        end
        for (int t = 5; t < 8; t++) push(1'b0, 1'(32'hD6 >> (7 - t)), "R3", q[7-t]);
        idle_end();
        chk_both_rem("R3", r);
    endtask

    task automatic t_clear();
        do_clear();
        for (int t = 0; t < 6; t++) push(1'b0, 1'b1, "R2", 1'b0 | ((t >= 4) ? 1'b1 : 1'b0));
        @(negedge clk); clear = 1'b1; valid = 1'b1; din = 1'b1;
        @(negedge clk); clear = 1'b0; valid = 1'b0;
        #1;
        chk_both_rem("R2", 4'h0);
    endtask

    task automatic t_empty();
        do_clear();
        @(negedge clk); valid = 1'b0; mode = 1'b0; din = 1'b1; #1;
        chk_both_q("R9", 1'b0);
        mode = 1'b1; din = 1'b1; #1;
        chk_both_q("R9", 1'b1);
        din = 1'b0; #1;
        chk_both_q("R9", 1'b0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_divide_patterns();
        t_multiply_patterns();
        t_hold();
        t_clear();
        t_empty();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule